// File: doc/BRIEF.md
# Serial Peripheral Master with Slave-Ready Gating

This block is a byte-wide serial master clocked from the system clock. It accepts a parallel word through a valid/ready handshake, sends it MSB first on the data-out pin while collecting eight bits from the data-in pin, and returns the received byte with a one-cycle done pulse. The serial clock is derived from a run-time divider value (`cfg_div` system clocks per bit, even, at least 2). All four polarity/phase combinations are selected by two configuration bits.

A transfer can be framed by an active-low select output, by a ready input driven by the slave, or by both. With the select option the master drops select on acceptance and holds off the first serial clock edge for a base of two system clocks plus a 5-bit programmable extension. With the ready option the master will not produce any serial clock edge until the slave raises ready. It then waits a fixed three system clocks. When phase is 1, half a bit period is added to whichever lead delay directly precedes the first edge. After the last edge of every word the master looks at ready again before it begins a queued word, so a slave can throttle back-to-back traffic.

Top module: `spi_hs_master`

## Requirements
- R1: With no transfer in progress `sclk` rests at `cfg_cpol`. Every word produces exactly 16 `sclk` transitions and leaves `sclk` back at `cfg_cpol`.
- R2: The word is sent MSB first on `mosi`. With `cfg_cpha`=0 the slave samples on transitions 1,3,...,15 and the first bit is on `mosi` before transition 1. With `cfg_cpha`=1 the slave samples on transitions 2,4,...,16.
- R3: `miso` is captured on the same transitions as in R2 and assembled MSB first. The result appears on `rx_data` while `rx_done` is high, and `rx_done` is high for exactly one cycle per word.
- R4: Select-only mode (`cfg_use_cs`=1, `cfg_use_ena`=0): `cs_n` goes low on the edge that accepts a word from idle. The first `sclk` transition follows 2 + `cfg_cs_dly` system clocks later, plus `cfg_div`/2 when `cfg_cpha`=1.
- R5: When `cfg_use_cs`=0, `cs_n` stays high at all times.
- R6: Ready mode: while `ena` is low and a word is waiting, `sclk` does not move. The first transition comes 3 system clocks after the clock edge at which `ena` is first sampled high, plus `cfg_div`/2 when `cfg_cpha`=1. If `ena` is already high on acceptance, the count starts from the accepting edge.
- R7: With both options set, `cs_n` drops on acceptance and the select delay of R4 runs without the half-bit term. Then the ready wait of R6 applies, including its half-bit term.
- R8: After the 16th transition a tail of 1 system clock follows, plus `cfg_div`/2 when `cfg_cpha`=0. `rx_done` is high in the cycle after the tail ends. If a word is pending in ready mode and `ena` is low at the end of the tail, no transition occurs until `ena` returns high. The R6 timing then applies.
- R9: `tx_ready` is high when idle and in the last tail cycle, so a pending word starts back to back. In select mode `cs_n` stays low across back-to-back words, and it returns high with `rx_done` when no word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on odd transitions; 1: sample on even transitions |
| cfg_use_cs | input | 1 | Drive the select output for each transfer |
| cfg_use_ena | input | 1 | Gate each transfer on the slave ready input |
| cfg_div | input | DIV_W | System clocks per serial bit, even, at least 2 |
| cfg_cs_dly | input | DLY_W | Extra select-to-clock system clocks |
| tx_valid | input | 1 | Word offered on tx_data |
| tx_data | input | WORD_W | Word to send |
| tx_ready | output | 1 | Master can take a word this cycle |
| rx_data | output | WORD_W | Received word |
| rx_done | output | 1 | One-cycle pulse, rx_data valid |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |
| ena | input | 1 | Slave ready, high to allow clocking |

## Verification
The embedded checks assume that the configuration inputs change only while the master is idle, that `cfg_div` is even and at least 2, and that `ena` and `miso` are synchronous to the system clock. The bench changes the mode only between words, after the done pulse. It then pauses a few cycles so that the idle clock level settles. It drives `ena` and `miso` only on falling clock edges, and it uses only even divider values from 2 to 10.

// File: rtl/spi_hs_pkg.sv
// Shared definitions for the serial master.
// Assumes: nothing beyond the parameters of the instantiating module.
package spi_hs_pkg;
    // Controller phases of one transfer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_WAIT,
        ST_SHIFT,
        ST_TAIL
    } spi_st_e;

    // Fixed system-clock lead after the ready input is seen high.
    localparam int unsigned ENA_LEAD = 3;
    // Minimum select-to-first-edge delay in system clocks.
    localparam int unsigned CS_BASE  = 2;
endpackage

// File: rtl/spi_hs_ctrl.sv
// Sequencer of the serial master: handles acceptance, the select and
// ready lead delays, serial clock generation, the post-word tail and
// back-to-back decisions. It emits per-edge launch/sample strobes.
// Assumes: cfg_* stable while busy, cfg_div even and >= 2, ena synchronous.
module spi_hs_ctrl
    import spi_hs_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 5,
    parameter int WORD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_use_cs,
    input  logic             cfg_use_ena,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [DLY_W-1:0] cfg_cs_dly,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic             ena,
    output logic             load,
    output logic             launch,
    output logic             sample,
    output logic             finish,
    output logic             sclk,
    output logic             cs_n
);
    localparam int EDGES  = 2 * WORD_W;
    localparam int ECNT_W = $clog2(EDGES + 1);
    localparam int CNT_W  = ((DIV_W > DLY_W) ? DIV_W : DLY_W) + 2;

    spi_st_e            st;
    logic [CNT_W-1:0]   cnt;
    logic [ECNT_W-1:0]  ecnt;
    logic               to_ena;
    logic               sclk_q;
    logic               cs_n_q;

    logic [CNT_W-1:0]   half;
    logic [CNT_W-1:0]   pha_add;
    logic [CNT_W-1:0]   cs_pha;
    logic [CNT_W-1:0]   d_ena_m1;
    logic [CNT_W-1:0]   d_cs_m1;
    logic [CNT_W-1:0]   tail_m1;
    logic [ECNT_W-1:0]  edge_n;
    logic               cnt_zero;
    logic               accept;
    logic               tgl;
    logic               last_edge;
    logic               ena_path;

    // Derive lead, tail and half-bit counts from the configuration.
    always_comb begin
        half     = CNT_W'(cfg_div >> 1);
        pha_add  = cfg_cpha ? half : '0;
        cs_pha   = cfg_use_ena ? '0 : pha_add;
        d_ena_m1 = CNT_W'(ENA_LEAD - 1) + pha_add;
        d_cs_m1  = CNT_W'(CS_BASE - 1) + CNT_W'(cfg_cs_dly) + cs_pha;
        tail_m1  = cfg_cpha ? '0 : half;
    end

    // Handshake and edge-event decode.
    always_comb begin
        cnt_zero  = (cnt == '0);
        tx_ready  = (st == ST_IDLE) || ((st == ST_TAIL) && cnt_zero);
        accept    = tx_valid && tx_ready;
        tgl       = cnt_zero && (((st == ST_LEAD) && !to_ena) || (st == ST_SHIFT));
        edge_n    = ecnt + 1'b1;
        last_edge = (edge_n == ECNT_W'(EDGES));
        ena_path  = cfg_use_ena && (!cfg_use_cs || !cs_n_q);
        load      = accept;
        finish    = (st == ST_TAIL) && cnt_zero;
        launch    = tgl && (cfg_cpha ? (edge_n[0] && (edge_n != ECNT_W'(1)))
                                     : (!edge_n[0] && !last_edge));
        sample    = tgl && (cfg_cpha ? !edge_n[0] : edge_n[0]);
    end

    // Transfer sequencer: state, delay counter, edge count and pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            ecnt   <= '0;
            to_ena <= 1'b0;
            sclk_q <= 1'b0;
            cs_n_q <= 1'b1;
        end else if (accept) begin
            cs_n_q <= !cfg_use_cs;
            ecnt   <= '0;
            if (ena_path) begin
                to_ena <= 1'b0;
                if (ena) begin
                    st  <= ST_LEAD;
                    cnt <= d_ena_m1;
                end else begin
                    st  <= ST_WAIT;
                end
            end else begin
                st     <= ST_LEAD;
                cnt    <= d_cs_m1;
                to_ena <= cfg_use_ena;
            end
        end else begin
            case (st)
                ST_IDLE: begin
                    sclk_q <= cfg_cpol;
                end
                ST_WAIT: begin
                    if (ena) begin
                        st  <= ST_LEAD;
                        cnt <= d_ena_m1;
                    end
                end
                ST_LEAD, ST_SHIFT: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else if (st == ST_LEAD && to_ena) begin
                        st     <= ST_WAIT;
                        to_ena <= 1'b0;
                    end else begin
                        sclk_q <= ~sclk_q;
                        ecnt   <= edge_n;
                        if (last_edge) begin
                            st  <= ST_TAIL;
                            cnt <= tail_m1;
                        end else begin
                            st  <= ST_SHIFT;
                            cnt <= half - 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        st     <= ST_IDLE;
                        cs_n_q <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign sclk = sclk_q;
    assign cs_n = cs_n_q;

    // R1
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt <= ECNT_W'(EDGES));

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |=> $stable(sclk_q));

    // R5
    no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_use_cs |-> cs_n_q);

    // R9
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> (st == ST_IDLE));

    // R8
    tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_TAIL) && !cnt_zero) |=> $stable(sclk_q));
endmodule

// File: rtl/spi_hs_shift.sv
// Data path of the serial master: transmit and receive shift registers.
// Shifts MSB first on strobes from the sequencer; presents the received
// word with a one-cycle done pulse.
// Assumes: load, launch and sample never coincide; 8 samples per word.
module spi_hs_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              launch,
    input  logic              sample,
    input  logic              finish,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_done
);
    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic              mosi_q;

    // Shift out on load/launch, shift in on sample, publish on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            mosi_q  <= 1'b0;
            rx_word <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= finish;
            if (finish) begin
                rx_word <= rx_sr;
            end
            if (load) begin
                mosi_q <= ld_word[WORD_W-1];
                tx_sr  <= {ld_word[WORD_W-2:0], 1'b0};
            end else if (launch) begin
                mosi_q <= tx_sr[WORD_W-1];
                tx_sr  <= {tx_sr[WORD_W-2:0], 1'b0};
            end
            if (sample) begin
                rx_sr <= {rx_sr[WORD_W-2:0], miso};
            end
        end
    end

    assign mosi = mosi_q;

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
endmodule

// File: rtl/spi_hs_master.sv
// Top of the serial master: ties the sequencer to the shift data path.
// Assumes: configuration changes only while idle; cfg_div even and >= 2.
module spi_hs_master #(
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 5,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_use_cs,
    input  logic              cfg_use_ena,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DLY_W-1:0]  cfg_cs_dly,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_done,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    input  logic              ena
);
    logic load, launch, sample, finish;

    spi_hs_ctrl #(.DIV_W(DIV_W), .DLY_W(DLY_W), .WORD_W(WORD_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_cpol    (cfg_cpol),
        .cfg_cpha    (cfg_cpha),
        .cfg_use_cs  (cfg_use_cs),
        .cfg_use_ena (cfg_use_ena),
        .cfg_div     (cfg_div),
        .cfg_cs_dly  (cfg_cs_dly),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .ena         (ena),
        .load        (load),
        .launch      (launch),
        .sample      (sample),
        .finish      (finish),
        .sclk        (sclk),
        .cs_n        (cs_n)
    );

    spi_hs_shift #(.WORD_W(WORD_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .ld_word (tx_data),
        .launch  (launch),
        .sample  (sample),
        .finish  (finish),
        .miso    (miso),
        .mosi    (mosi),
        .rx_word (rx_data),
        .rx_done (rx_done)
    );
endmodule

// File: tb/spi_hs_master_tb.sv
`timescale 1ns/1ps
module spi_hs_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_use_cs = 1'b1, cfg_use_ena = 1'b0;
    logic [7:0] cfg_div = 8'd4;
    logic [4:0] cfg_cs_dly = 5'd0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       ena = 1'b1;
    logic       miso;
    logic       tx_ready, rx_done, sclk, mosi, cs_n;
    logic [7:0] rx_data;

    spi_hs_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_use_cs(cfg_use_cs), .cfg_use_ena(cfg_use_ena), .cfg_div(cfg_div),
        .cfg_cs_dly(cfg_cs_dly), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_done(rx_done), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n), .ena(ena)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] exp_tx[$], exp_rx[$], slave_q[$];
    int  bn = 0, edge_total = 0, first_edge_cyc = 0, last_edge_cyc = 0;
    int  done_cnt = 0, done_cyc = 0, cs_rise = 0, cs_lo = 0, acc_cyc = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1, loaded = 1'b0, mon_hold = 1'b0;
    logic [7:0] s_word = 8'd0, s_rx = 8'd0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor and slave model: edges, slave data, scoreboard pops.
    always @(negedge clk) begin
        if (!rst_n || mon_hold) begin
            prev_sclk = sclk;
            if (!rst_n) begin bn = 0; loaded = 1'b0; miso = 1'b0; prev_cs = 1'b1; end
        end else begin
            if (sclk !== prev_sclk) begin
                bn++; edge_total++; last_edge_cyc = cyc;
                if (bn == 1) first_edge_cyc = cyc;
                if (cfg_cpha ? (bn % 2 == 0) : (bn % 2 == 1)) s_rx = {s_rx[6:0], mosi};
                if (!cfg_cpha && bn % 2 == 0 && bn < 16) miso = s_word[7 - bn / 2];
                if (cfg_cpha && bn % 2 == 1 && bn > 1) miso = s_word[7 - (bn - 1) / 2];
                if (bn == 16) begin
                    if (exp_tx.size() > 0) chk("R2", "mosi word", int'(s_rx), int'(exp_tx.pop_front()));
                    else chk("R2", "unexpected word", 1, 0);
                    bn = 0; loaded = 1'b0;
                end
            end
            prev_sclk = sclk;
            if (!loaded && slave_q.size() > 0) begin
                s_word = slave_q.pop_front(); miso = s_word[7]; loaded = 1'b1;
            end
            if (rx_done) begin
                done_cnt++; done_cyc = cyc;
                if (exp_rx.size() > 0) chk("R3", "rx_data", int'(rx_data), int'(exp_rx.pop_front()));
                else chk("R3", "unexpected done", 1, 0);
            end
            if (cs_n && !prev_cs) cs_rise++;
            if (!cs_n) cs_lo++;
            prev_cs = cs_n;
        end
    end

    // Driver: queue expectations, then offer the word until accepted.
    task automatic send(input logic [7:0] w, input logic [7:0] sw);
        exp_tx.push_back(w); exp_rx.push_back(sw); slave_q.push_back(sw);
        tx_valid = 1'b1; tx_data = w;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        acc_cyc = cyc;
        tx_valid = 1'b0;
    endtask

    task automatic wait_done(input int n);
        int d0 = done_cnt;
        while (done_cnt < d0 + n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic pol, input logic pha, input logic ucs,
                            input logic uena, input int div, input int dly);
        mon_hold = 1'b1;
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_use_cs = ucs; cfg_use_ena = uena;
        cfg_div = 8'(div); cfg_cs_dly = 5'(dly);
        repeat (3) @(negedge clk);
        mon_hold = 1'b0;
        @(negedge clk);
        chk("R1", "idle sclk level", int'(sclk), int'(pol));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e0, rc, lo0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4", "reset cs_n", int'(cs_n), 1);
        chk("R1", "reset sclk", int'(sclk), 0);
        chk("R9", "reset tx_ready", int'(tx_ready), 1);
        chk("R3", "reset rx_done", int'(rx_done), 0);

        // Select-only, all four modes, delay extension 0..3.
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0], 1'b1, 1'b0, 4, m);
            send(8'hA5 ^ 8'(m * 17), 8'h3C + 8'(m * 29));
            chk("R4", "cs_n low after accept", int'(cs_n), 0);
            wait_done(1);
            chk("R4", "cs to first edge", first_edge_cyc - acc_cyc, 2 + m + (m[0] ? 2 : 0));
            chk("R8", "tail length", done_cyc - last_edge_cyc, 1 + (m[0] ? 0 : 2));
            chk("R1", "sclk back to idle", int'(sclk), int'(m[1]));
            chk("R9", "cs_n released", int'(cs_n), 1);
        end

        // Ready-only: hold off while ena low, both phases.
        for (int p = 0; p < 2; p++) begin
            set_mode(1'b0, p[0], 1'b0, 1'b1, 6, 0);
            lo0 = cs_lo;
            ena = 1'b0;
            e0 = edge_total;
            send(8'h96 + 8'(p), 8'h5A - 8'(p));
            repeat (20) @(negedge clk);
            chk("R6", "no edges while ena low", edge_total, e0);
            ena = 1'b1; rc = cyc;
            wait_done(1);
            chk("R6", "ena to first edge", first_edge_cyc, rc + 1 + 3 + (p == 1 ? 3 : 0));
            chk("R5", "cs_n never low", cs_lo, lo0);
        end

        // Ready already high on acceptance.
        set_mode(1'b1, 1'b1, 1'b0, 1'b1, 2, 0);
        send(8'hC3, 8'h81);
        wait_done(1);
        chk("R6", "ena high at accept", first_edge_cyc - acc_cyc, 3 + 1);

        // Both options: select first, then ready gating.
        set_mode(1'b0, 1'b0, 1'b1, 1'b1, 4, 2);
        ena = 1'b0;
        e0 = edge_total;
        send(8'h0F, 8'hF0);
        repeat (30) @(negedge clk);
        chk("R7", "cs_n low while waiting", int'(cs_n), 0);
        chk("R7", "no edges before ena", edge_total, e0);
        ena = 1'b1; rc = cyc;
        wait_done(1);
        chk("R7", "ena to first edge", first_edge_cyc, rc + 1 + 3);

        // Back-to-back in ready mode with ena dropped inside the tail.
        set_mode(1'b0, 1'b0, 1'b0, 1'b1, 8, 0);
        ena = 1'b1;
        e0 = edge_total;
        fork
            begin send(8'h12, 8'hED); send(8'h34, 8'hCB); end
        join_none
        while (edge_total < e0 + 16) @(negedge clk);
        ena = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8", "held after tail with ena low", edge_total, e0 + 16);
        ena = 1'b1; rc = cyc;
        wait_done(1);
        chk("R8", "resume after ena", first_edge_cyc, rc + 1 + 3);

        // Back-to-back in select mode keeps cs_n low between words.
        set_mode(1'b0, 1'b1, 1'b1, 1'b0, 2, 1);
        r0 = cs_rise;
        fork
            begin send(8'h55, 8'h99); send(8'hAA, 8'h66); end
        join_none
        wait_done(2);
        chk("R9", "single cs_n release", cs_rise, r0 + 1);

        // Larger divider, mode 3.
        set_mode(1'b1, 1'b1, 1'b1, 1'b0, 10, 31);
        send(8'h01, 8'h80);
        wait_done(1);
        chk("R4", "max extension delay", first_edge_cyc - acc_cyc, 2 + 31 + 5);
        chk("R3", "scoreboard drained", exp_rx.size(), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule